// File: doc/BRIEF.md
# Three-Ones Serial Run Detector

This block watches a one-bit serial stream, taking one bit per rising clock edge, and raises a flag in the same cycle as the third one of an unbroken run of ones. It is a Mealy machine. A two-bit state register counts how many ones have arrived in a row. Fixed Boolean equations compute the next state and the flag from that register and the current input bit.

When a run is detected, the count starts again from zero. Runs therefore do not overlap: six ones in a row give two detections, not four. A zero at any point clears the count. A synchronous active-high reset puts the machine back in its starting state. The fourth two-bit pattern is never used. If it ever appears, the same equations still give a fixed next state.

Top module: `triple_one_detector`

## Requirements
- R1: The state is held in two bits. The start state (no ones seen) is 00, "one one seen" is 01 and "two ones seen" is 10. The machine begins in the start state after reset.
- R2: When `rst` is high at a rising edge, the state becomes 00. If `bit_in` is then held at 1, `hit_out` stays low on the first two ones after reset.
- R3: Each rising edge with `bit_in` at 1 moves the state from 00 to 01 and from 01 to 10.
- R4: A rising edge with `bit_in` at 0 returns the state to 00 from any state. `hit_out` is 0 in every cycle where `bit_in` is 0.
- R5: `hit_out` is combinational and equals state bit 1 AND `bit_in`. It is high in the same cycle that the third consecutive one is presented, before the edge that takes that bit in.
- R6: A detection returns the state to 00, so detections never overlap. The stream 111111 gives `hit_out` high on the 3rd and 6th ones only.
- R7: The machine never enters encoding 11 from a legal state. If 11 is ever held, the next state is 10 on input 1 and 00 on input 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit sampled each rising edge |
| hit_out | output | 1 | High while the third consecutive one is presented |

## Verification
`hit_out` is a combinational (Mealy) output, so its expected value is due in the same cycle that `bit_in` is presented, with no register delay. The state change caused by that bit shows up one rising edge later, in the value `hit_out` takes for the next input. The bench drives `bit_in` on the falling edge and compares `hit_out` with a behavioural run counter a few nanoseconds before the next rising edge. The bench updates its counter only at that edge, so each comparison matches exactly one cycle of the design.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int STATE_W = 2;
   localparam logic [STATE_W-1:0] ST_IDLE = 2'b00;
   localparam logic [STATE_W-1:0] ST_ONE  = 2'b01;
   localparam logic [STATE_W-1:0] ST_TWO  = 2'b10;
   localparam logic [STATE_W-1:0] ST_VOID = 2'b11;
endpackage

// File: rtl/tod_next_state.sv
module tod_next_state
   import tod_pkg::*;
#(
   parameter int W = STATE_W
) (
   input  logic [W-1:0] cur_st,
   input  logic         din,
   output logic [W-1:0] nxt_st
);
   if (W != 2) begin : g_bad_width
      $error("tod_next_state: state width must be 2");
   end

   // Equation form: high bit follows low bit AND input,
   // low bit set only from the all-zero state on a one.
   always_comb begin
      nxt_st    = '0;
      nxt_st[1] = cur_st[0] & din;
      nxt_st[0] = ~cur_st[1] & ~cur_st[0] & din;
   end
endmodule

// File: rtl/tod_output.sv
module tod_output
   import tod_pkg::*;
#(
   parameter int W = STATE_W
) (
   input  logic [W-1:0] cur_st,
   input  logic         din,
   output logic         hit
);
   if (W != 2) begin : g_bad_width
      $error("tod_output: state width must be 2");
   end

   always_comb hit = cur_st[1] & din;
endmodule

// File: rtl/tod_state_reg.sv
module tod_state_reg
   import tod_pkg::*;
#(
   parameter int W = STATE_W,
   parameter logic [W-1:0] RST_VAL = ST_IDLE
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= d;
   end

   AST_RESET_TO_IDLE: assert property (@(posedge clk) rst |=> (q == RST_VAL)) // R2
      else $error("state not cleared by reset");
endmodule

// File: rtl/triple_one_detector.sv
module triple_one_detector
   import tod_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic hit_out
);
   logic [STATE_W-1:0] st_q;
   logic [STATE_W-1:0] st_d;

   tod_next_state #(.W(STATE_W)) u_next (
      .cur_st (st_q),
      .din    (bit_in),
      .nxt_st (st_d)
   );

   tod_state_reg #(.W(STATE_W), .RST_VAL(ST_IDLE)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (st_d),
      .q   (st_q)
   );

   tod_output #(.W(STATE_W)) u_out (
      .cur_st (st_q),
      .din    (bit_in),
      .hit    (hit_out)
   );

   AST_IDLE_TO_ONE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && bit_in) |=> (st_q == ST_ONE)) // R3
      else $error("idle did not advance on a one");
   AST_ONE_TO_TWO: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_ONE && bit_in) |=> (st_q == ST_TWO)) // R3
      else $error("one-state did not advance on a one");
   AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
      !bit_in |=> (st_q == ST_IDLE)) // R4
      else $error("zero did not return to idle");
   AST_HIT_IN_TWO: assert property (@(posedge clk) disable iff (rst)
      hit_out |-> (st_q == ST_TWO && bit_in)) // R5
      else $error("hit outside the two-ones state");
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      hit_out |=> (st_q == ST_IDLE)) // R6
      else $error("detection did not restart the count");
   AST_NEVER_VOID: assert property (@(posedge clk) disable iff (rst)
      (st_q != ST_VOID) |=> (st_q != ST_VOID)) // R7
      else $error("unused encoding entered");
   AST_VOID_EXIT: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_VOID) |=> (st_q == (bit_in ? ST_TWO : ST_IDLE))) // R7
      else $error("unused encoding exit not as specified");
endmodule

// File: tb/triple_one_detector_bench.sv
module triple_one_detector_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic hit_out;
   int   n_tests = 0;
   int   n_fail  = 0;
   int   run_cnt = 0;   // behavioural count of consecutive ones

   triple_one_detector u_triple_one_detector (
      .clk     (clk),
      .rst     (rst),
      .bit_in  (bit_in),
      .hit_out (hit_out)
   );

   always #5 clk = ~clk;

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // One cycle: drive on falling edge, compare before rising edge, update model at edge.
   task automatic step(input logic b, input logic r, input string tag);
      logic exp;
      @(negedge clk);
      bit_in = b;
      rst    = r;
      #3;
      exp = (run_cnt == 2) && b;
      n_tests++;
      if (hit_out !== exp) begin
         n_fail++;
         $display("FAIL %s: hit_out=%b expected=%b (run=%0d in=%b)", tag, hit_out, exp, run_cnt, b);
      end
      @(posedge clk);
      if (r)       run_cnt = 0;
      else if (!b) run_cnt = 0;
      else if (run_cnt == 2) run_cnt = 0;
      else         run_cnt = run_cnt + 1;
   endtask

   initial begin
      logic [7:0] lfsr;
      // Initial reset, unchecked until the register is known.
      @(posedge clk);
      @(posedge clk);
      run_cnt = 0;
      // R2: after reset, first two ones give no hit; R1 start state
      step(1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, "R1");
      step(1'b1, 1'b0, "R3");
      // R6: six ones -> hits on 3rd and 6th only
      step(1'b0, 1'b0, "R4");
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R6");
      // R4: zero breaks a run of two
      step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      // R5: hit coincides with the third one
      step(1'b1, 1'b0, "R5");
      step(1'b1, 1'b0, "R5");
      // R2: reset in the middle of a run
      step(1'b0, 1'b0, "R2");
      step(1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, "R2");
      step(1'b1, 1'b1, "R2");
      step(1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, "R2");
      step(1'b1, 1'b0, "R2");
      // R3/R7: pseudo-random stream; any entry into 11 would show as a mismatch
      lfsr = 8'hA5;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(lfsr[0] | lfsr[2], 1'b0, "R7");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule